// File: doc/BRIEF.md
# Triaxial Sample Buffer with Selectable Fill Policy

This block stores acceleration samples, one X, one Y and one Z value of 16 bits each, as triplets in a 32-level queue. The sample source raises a valid strobe with a fresh triplet on every conversion. The host drains the queue through a byte-wide read window of six addresses. A fill policy is picked at run time. The block can pass samples straight through. It can fill once and then stop. It can keep the newest samples by dropping the oldest. It can also keep the newest samples until an event fires, then fill the remaining space and freeze, so the history around the event is kept.

The read window covers addresses 0x28 to 0x2D. A read at a byte address sets an internal cursor. Each further read advances the cursor by one. When the read at 0x2D completes, the cursor returns to 0x28 and the oldest triplet leaves the queue. A host can therefore empty a full buffer with one burst of 192 byte reads. Two status outputs are provided. One shows that the fill level has passed a programmed mark. The other shows that a sample was lost or overwritten. Both are meant to drive interrupt lines.

Top module: `triax_sample_fifo`

## Requirements
- R1: After reset, level is 0, wtm_flag and ovr_flag are low, rd_data is 0x00 and the read cursor points at 0x28.
- R2: When buffering is active, level counts the stored triplets and never exceeds DEPTH (32).
- R3: In mode 2'b01 (stop-when-full), a sample that arrives while 32 levels are stored and no level is removed in the same cycle is discarded, the stored data is unchanged and ovr_flag rises on the next cycle.
- R4: In mode 2'b10 (overwrite), a sample that arrives while full with no removal in the same cycle discards the oldest level, is appended, keeps level at 32 and sets ovr_flag.
- R5: In mode 2'b11, the buffer behaves as mode 2'b10 until trig has been seen high on a clock edge, and as mode 2'b01 from the following cycle onward. The trigger memory clears whenever another mode is selected.
- R6: Buffering is active only when fifo_en is 1 and mode is not 2'b00. While it is inactive the buffer is emptied, ovr_flag is cleared, no read removes a level, and reads show the most recent sample.
- R7: wtm_flag is 1 exactly while level is strictly greater than wtm_lvl.
- R8: A read returns its byte on rd_data one cycle after rd_en. Addresses 0x28..0x2D give X low, X high, Y low, Y high, Z low and Z high of the oldest stored triplet. Any other address gives 0x00.
- R9: The address of each read is rd_addr when rd_load is high in that cycle and the cursor otherwise. The cursor then moves to that address plus one, except that 0x2D is followed by 0x28. A read of 0x2D while active removes the oldest level, so 192 reads from 0x28 empty a full buffer.
- R10: ovr_flag stays set until a level is removed in a cycle with no new loss. It then clears on the next cycle.
- R11: When buffering is active but the buffer is empty, the window shows the most recent sample, and a read of 0x2D removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Buffer enable; when low the block passes samples straight through |
| mode | input | 2 | Fill policy: 00 pass-through, 01 stop-when-full, 10 overwrite, 11 overwrite-then-stop on trigger |
| wtm_lvl | input | 5 | Watermark mark compared against the level |
| trig | input | 1 | Event input for mode 11 |
| smp_valid | input | 1 | New triplet present on smp_x/y/z |
| smp_x | input | 16 | X sample |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| rd_load | input | 1 | Use rd_addr as the address of this read, or load the cursor |
| rd_addr | input | 8 | Byte address to load |
| rd_en | input | 1 | Perform one byte read |
| rd_data | output | 8 | Read byte, valid the cycle after rd_en |
| level | output | 6 | Number of stored triplets |
| wtm_flag | output | 1 | Level above watermark |
| ovr_flag | output | 1 | A sample was discarded or overwritten |

## Verification
The bench builds the block with DEPTH left at 32 and 16-bit axes. At that size a full fill, overflow in every policy and a 192-byte drain burst each take only a few hundred cycles. The full 5-bit watermark range is therefore reachable, including marks near the top of the buffer. The reference queue predicts every byte of the drain, and the bench checks it cycle by cycle. This covers the wrap at 0x2D, removal while samples still arrive, and the transition from empty to the most recent sample.

// File: rtl/triax_fifo_pkg.sv
package triax_fifo_pkg;
  localparam int SMP_W  = 16;
  localparam int WORD_W = 3 * SMP_W;

  typedef enum logic [1:0] {
    FM_PASS   = 2'b00,
    FM_HOLD   = 2'b01,
    FM_STREAM = 2'b10,
    FM_TRIG   = 2'b11
  } fmode_e;

  localparam logic [7:0] WIN_LO = 8'h28;
  localparam logic [7:0] WIN_HI = 8'h2D;
endpackage

// File: rtl/triax_fifo_store.sv
module triax_fifo_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 48,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic              ovw_ok,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              loss,
  output logic              popped
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              wr_en;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LVL_W'(DEPTH));

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_d  = lvl_q;
    wr_en  = 1'b0;
    loss   = 1'b0;
    popped = 1'b0;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (pop && !empty) begin
        popped = 1'b1;
        rd_d   = nxt(rd_q);
        lvl_d  = lvl_q - 1'b1;
      end
      if (push) begin
        if (!full || popped) begin
          wr_en = 1'b1;
          wr_d  = nxt(wr_q);
          lvl_d = lvl_d + 1'b1;
        end else if (ovw_ok) begin
          wr_en = 1'b1;
          wr_d  = nxt(wr_q);
          rd_d  = nxt(rd_q);
          loss  = 1'b1;
        end else begin
          loss = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/triax_fifo_policy.sv
module triax_fifo_policy
  import triax_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic [1:0] mode,
  input  logic       trig,
  input  logic       loss,
  input  logic       popped,
  output logic       active,
  output logic       ovw_ok,
  output logic       ovr_flag
);
  fmode_e fm;
  logic   armed_q, armed_d;
  logic   ovr_q, ovr_d;

  assign fm     = fmode_e'(mode);
  assign active = fifo_en && (fm != FM_PASS);
  assign ovw_ok = (fm == FM_STREAM) || ((fm == FM_TRIG) && !armed_q);

  always_comb begin
    armed_d = armed_q;
    ovr_d   = ovr_q;
    if (!active) begin
      armed_d = 1'b0;
      ovr_d   = 1'b0;
    end else begin
      armed_d = (fm == FM_TRIG) ? (armed_q | trig) : 1'b0;
      if (loss)        ovr_d = 1'b1;
      else if (popped) ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      ovr_q   <= ovr_d;
    end
  end

  assign ovr_flag = ovr_q;
endmodule

// File: rtl/triax_fifo_rdport.sv
module triax_fifo_rdport
  import triax_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_load,
  input  logic [7:0]        rd_addr,
  input  logic              rd_en,
  input  logic              active,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  input  logic [WORD_W-1:0] latest,
  output logic [7:0]        rd_data,
  output logic              pop_req
);
  logic [7:0]        cur_q, cur_d, eff;
  logic [7:0]        dat_q, dat_d;
  logic [WORD_W-1:0] src;
  logic [2:0]        idx;
  logic              in_win;

  assign eff    = rd_load ? rd_addr : cur_q;
  assign in_win = (eff >= WIN_LO) && (eff <= WIN_HI);
  assign idx    = 3'(eff - WIN_LO);
  assign src    = (active && !empty) ? head : latest;

  always_comb begin
    cur_d   = cur_q;
    dat_d   = dat_q;
    pop_req = 1'b0;
    if (rd_en) begin
      dat_d = in_win ? src[idx*8 +: 8] : 8'h00;
      if (eff == WIN_HI) begin
        cur_d   = WIN_LO;
        pop_req = active;
      end else begin
        cur_d = eff + 1'b1;
      end
    end else if (rd_load) begin
      cur_d = rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= WIN_LO;
      dat_q <= 8'h00;
    end else begin
      cur_q <= cur_d;
      dat_q <= dat_d;
    end
  end

  assign rd_data = dat_q;
endmodule

// File: rtl/triax_sample_fifo.sv
module triax_sample_fifo
  import triax_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WTM_W = 5,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       mode,
  input  logic [WTM_W-1:0] wtm_lvl,
  input  logic             trig,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  input  logic             rd_load,
  input  logic [7:0]       rd_addr,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [LVL_W-1:0] level,
  output logic             wtm_flag,
  output logic             ovr_flag
);
  logic [WORD_W-1:0] word_in, head, latest_q;
  logic active, ovw_ok, empty, full, loss, popped, pop_req;

  assign word_in = {smp_z, smp_y, smp_x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latest_q <= '0;
    else if (smp_valid) latest_q <= word_in;
  end

  triax_fifo_policy u_pol (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode(mode), .trig(trig),
    .loss(loss), .popped(popped), .active(active), .ovw_ok(ovw_ok),
    .ovr_flag(ovr_flag)
  );

  triax_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(!active), .push(smp_valid), .pop(pop_req),
    .ovw_ok(ovw_ok), .din(word_in), .head(head), .level(level), .empty(empty),
    .full(full), .loss(loss), .popped(popped)
  );

  triax_fifo_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_addr(rd_addr),
    .rd_en(rd_en), .active(active), .empty(empty), .head(head),
    .latest(latest_q), .rd_data(rd_data), .pop_req(pop_req)
  );

  assign wtm_flag = (int'(level) > int'(wtm_lvl));
endmodule

// File: rtl/triax_fifo_chk.sv
module triax_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic [1:0]       mode,
  input logic             smp_valid,
  input logic             pop_req,
  input logic [LVL_W-1:0] level,
  input logic             ovr_flag
);
  logic act;
  assign act = fifo_en && (mode != 2'b00);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  assert_inactive_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (level == '0) && !ovr_flag);

  assert_hold_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode == 2'b01 && int'(level) == DEPTH && smp_valid && !pop_req)
    |=> ovr_flag && int'(level) == DEPTH);

  assert_stream_ovw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode == 2'b10 && int'(level) == DEPTH && smp_valid && !pop_req)
    |=> ovr_flag && int'(level) == DEPTH);

  assert_ovr_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ovr_flag && pop_req && level != '0 && !smp_valid) |=> !ovr_flag);
endmodule

bind triax_sample_fifo triax_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode(mode),
  .smp_valid(smp_valid), .pop_req(pop_req), .level(level), .ovr_flag(ovr_flag)
);

// File: tb/tb_triax_sample_fifo.sv
module tb_triax_sample_fifo;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n, fifo_en, trig, smp_valid, rd_load, rd_en;
  logic [1:0] mode;
  logic [4:0] wtm_lvl;
  logic [15:0] smp_x, smp_y, smp_z;
  logic [7:0] rd_addr, rd_data;
  logic [5:0] level;
  logic wtm_flag, ovr_flag;

  always #(CLK_T/2) clk = ~clk;

  triax_sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode(mode),
    .wtm_lvl(wtm_lvl), .trig(trig), .smp_valid(smp_valid), .smp_x(smp_x),
    .smp_y(smp_y), .smp_z(smp_z), .rd_load(rd_load), .rd_addr(rd_addr),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .wtm_flag(wtm_flag),
    .ovr_flag(ovr_flag)
  );

  int vecs = 0, bad = 0, seq = 0;
  bit done = 0;
  string tag = "R1";

  logic [47:0] q[$];
  logic [47:0] m_latest;
  logic [7:0]  m_cur, m_rd;
  bit m_ovr, m_armed;

  task automatic cmp(string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model();
    bit act, ow, popq, didpop, evt;
    logic [7:0] eff;
    logic [47:0] src;
    if (!rst_n) begin
      q.delete(); m_latest = '0; m_cur = 8'h28; m_rd = 8'h00; m_ovr = 0; m_armed = 0;
      return;
    end
    act  = fifo_en && (mode != 2'b00);
    popq = 0;
    if (rd_en) begin
      eff = rd_load ? rd_addr : m_cur;
      src = (act && q.size() > 0) ? q[0] : m_latest;
      m_rd = (eff >= 8'h28 && eff <= 8'h2D) ? src[(eff-8'h28)*8 +: 8] : 8'h00;
      if (eff == 8'h2D) begin m_cur = 8'h28; popq = act; end
      else m_cur = eff + 8'd1;
    end else if (rd_load) m_cur = rd_addr;
    if (!act) begin
      q.delete(); m_ovr = 0; m_armed = 0;
    end else begin
      ow = (mode == 2'b10) || (mode == 2'b11 && !m_armed);
      didpop = popq && q.size() > 0;
      if (didpop) void'(q.pop_front());
      evt = 0;
      if (smp_valid) begin
        if (q.size() < 32) q.push_back({smp_z, smp_y, smp_x});
        else if (ow) begin void'(q.pop_front()); q.push_back({smp_z, smp_y, smp_x}); evt = 1; end
        else evt = 1;
      end
      if (evt) m_ovr = 1; else if (didpop) m_ovr = 0;
      m_armed = (mode == 2'b11) ? (m_armed | trig) : 0;
    end
    if (smp_valid) m_latest = {smp_z, smp_y, smp_x};
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    if (done) return;
    cmp("level", level, q.size());
    cmp("ovr_flag", ovr_flag, m_ovr);
    cmp("wtm_flag", wtm_flag, (q.size() > wtm_lvl) ? 1 : 0);
    cmp("rd_data", rd_data, m_rd);
    smp_valid = 0; rd_en = 0; rd_load = 0; trig = 0;
  endtask

  task automatic put(int n);
    for (int i = 0; i < n; i++) begin
      seq++;
      smp_valid = 1;
      smp_x = 16'h1000 + 16'(seq);
      smp_y = 16'h2000 + 16'(seq * 3);
      smp_z = ~(16'h1000 + 16'(seq));
      tick();
    end
  endtask

  task automatic rd(int n, int start);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      if (i == 0 && start >= 0) begin rd_load = 1; rd_addr = 8'(start); end
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_en = 0; mode = 2'b00; wtm_lvl = 5'd10; trig = 0;
    smp_valid = 0; smp_x = 0; smp_y = 0; smp_z = 0; rd_load = 0; rd_addr = 0; rd_en = 0;
    @(negedge clk);
    tag = "R1"; tick(); tick();
    rst_n = 1; tick();
    // R6 pass-through: latest sample shown, R8 byte order and outside addresses
    tag = "R6"; fifo_en = 1; mode = 2'b00; put(3);
    tag = "R8"; rd(8, 'h27); rd(2, 'h2D);
    // R2 R3 R7 stop-when-full, overflow and watermark
    tag = "R2"; mode = 2'b01; put(12);
    tag = "R7"; put(18);
    tag = "R3"; put(5);
    // R9 full drain by burst, R10 overrun release, R11 empty window
    tag = "R9"; rd(96, 'h28);
    tag = "R10"; rd(96, -1);
    tag = "R11"; rd(7, -1); put(1); rd(6, 'h28);
    // R4 overwrite policy, with reads while samples arrive
    tag = "R4"; mode = 2'b10; wtm_lvl = 5'd31; put(40);
    rd(6, 'h28); put(2); rd(12, -1);
    for (int i = 0; i < 20; i++) begin rd_en = 1; smp_valid = 1; seq++; smp_x = 16'(seq); tick(); end
    // R5 trigger switches overwrite to stop-when-full
    tag = "R5"; mode = 2'b00; tick(); mode = 2'b11; put(40);
    trig = 1; tick(); rd(6, 'h28); put(8);
    rd(30, 'h28); put(10);
    tag = "R6"; fifo_en = 0; mode = 2'b01; tick(); put(2); rd(6, 'h28);
    fifo_en = 1; put(4); mode = 2'b00; tick(); rd(6, 'h28);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule